// File: doc/BRIEF.md
# I2C Multi-Segment Transaction Sequencer

This block runs a whole I2C transaction without software in the loop. It drives a register-mapped byte-level bus controller: it issues one command at a time and polls the controller's transfer-in-progress, bus-busy, no-acknowledge and arbitration-lost flags. The transaction is a chain of segments. Each segment carries a 7- or 10-bit target address, a direction, a no-restart flag, a last flag and a byte count. The sequencer sends the address byte or bytes and moves the data. It joins segments with a repeated START, or with no START when the segment is flagged no-restart. It closes the bus with STOP and finishes with an interrupt-acknowledge command.

Segment descriptors, write data and read data all use valid/ready streams. A descriptor is taken only when the sequencer is idle or between segments. The sequencer pulls write bytes one at a time, just before each write command, so a stalled source simply delays the next command. Each read byte is held on the read stream until the sink accepts it. No further command is issued before that, so a slow sink back-pressures the bus. The block ends each transaction with a one-cycle `done` pulse, or with a one-cycle `err` pulse and an error code. A programmable no-progress watchdog sets an upper bound on every wait.

Top module: `i2c_seg_seq`

## Requirements
- R1: After accepting the first descriptor, the sequencer issues no command while `ctl_busy` or `ctl_tip` is high. If the watchdog expires in this wait, it reports `err` with code 1 (bus busy) and issues no command.
- R2: For a 7-bit address, the first command is START (0x91). Its data byte is {addr[6:0], rd}, where rd=1 means read.
- R3: For a 10-bit address, the first command is START (0x91) with data {5'b11110, addr[9:8], rd}. After that byte completes, a WRITE (0x11) follows with data addr[7:0].
- R4: Each byte of a write segment is taken from the write stream and sent, in stream order, with a WRITE command (0x11) whose data is that byte. A zero-length segment sends only its address.
- R5: Each read byte is requested with READ+ACK (0x21), except the last byte of the segment, which uses READ+NACK (0x29). The byte returned on `ctl_rdata` appears on the read stream and stays stable until `rd_ready`.
- R6: If `ctl_nack` is high when an address or write byte completes, the next command is STOP (0x41), then IACK (0x01), and the sequencer reports `err` with code 2.
- R7: If `ctl_arblost` is high when any command other than STOP completes, the sequencer issues STOP, then IACK, and reports `err` with code 3. A byte whose read lost arbitration is not delivered.
- R8: When a segment without the last flag ends, the next descriptor is fetched. Without no-restart, it starts again with the address phase (a repeated START). With no-restart, its data commands follow at once, with no address.
- R9: After the last segment, the sequencer issues STOP. Once `ctl_tip` clears, it issues IACK (0x01) and pulses `done` in the same cycle.
- R10: A command is issued only after `ctl_tip` has been seen low. Two command pulses are always at least two cycles apart.
- R11: If `timeout_cycles` cycles pass with no command issued and no stream handshake (outside the busy wait), the transaction ends with `err` and code 4. No STOP is issued.
- R12: After reset, `seg_ready` is high and `ctl_cmd_valid`, `done`, `err` and `rd_valid` are low. `seg_ready` is low while a segment is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timeout_cycles | input | WD_W | No-progress limit in cycles |
| seg_valid | input | 1 | Descriptor valid |
| seg_ready | output | 1 | Descriptor accepted when high with valid |
| seg_addr | input | 10 | Target address (7-bit uses [6:0]) |
| seg_ten | input | 1 | 10-bit address form |
| seg_rd | input | 1 | Read segment when high |
| seg_nors | input | 1 | Continue previous segment without START |
| seg_last | input | 1 | Final segment of the transaction |
| seg_len | input | LEN_W | Byte count of the segment |
| wd_valid | input | 1 | Write byte valid |
| wd_ready | output | 1 | Write byte taken |
| wd_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Read byte accepted |
| rd_data | output | 8 | Read byte |
| ctl_cmd_valid | output | 1 | One-cycle command strobe to controller |
| ctl_cmd | output | 8 | Command code |
| ctl_wdata | output | 8 | Data byte loaded with the command |
| ctl_tip | input | 1 | Controller transfer in progress |
| ctl_busy | input | 1 | Bus owned by another master |
| ctl_nack | input | 1 | Last byte was not acknowledged |
| ctl_arblost | input | 1 | Arbitration lost |
| ctl_rdata | input | 8 | Last byte received |
| done | output | 1 | Transaction completed pulse |
| err | output | 1 | Transaction failed pulse |
| err_code | output | 3 | 1 busy, 2 no-ack, 3 arbitration, 4 timeout |

## Verification
A wrong phase or position register shows up at the controller port. The command after the faulty step carries the wrong code or data byte: ACK instead of NACK on the final read, a missing second address byte, or a missing START between segments. The bench logs every command, so this is caught at the first wrong strobe. A lost error or watchdog state shows as a missing STOP, a wrong error code, or a transaction that never ends. The bench bounds each transaction, so a hang is caught within one watchdog interval. Read-path faults show as wrong or reordered bytes on the read stream.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  // Command bytes decoded by the byte controller (bit-mapped: start, stop,
  // read, write, nack, irq-ack).
  localparam logic [7:0] CMD_START   = 8'h91;
  localparam logic [7:0] CMD_WRITE   = 8'h11;
  localparam logic [7:0] CMD_RD_ACK  = 8'h21;
  localparam logic [7:0] CMD_RD_NACK = 8'h29;
  localparam logic [7:0] CMD_STOP    = 8'h41;
  localparam logic [7:0] CMD_IACK    = 8'h01;

  localparam int ADDR_W = 10;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_BUSY    = 3'd1,
    ERR_NACK    = 3'd2,
    ERR_ARB     = 3'd3,
    ERR_TIMEOUT = 3'd4
  } err_e;

  typedef enum logic [2:0] {
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_WRITE,
    PH_READ,
    PH_STOP
  } phase_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_INIT,
    S_ADDR,
    S_WAIT,
    S_POLL,
    S_NEXT,
    S_WDATA,
    S_RDOUT,
    S_FETCH
  } state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              ten;
    logic              rd;
    logic              last;
  } seg_t;

endpackage

// File: rtl/i2cs_addr_fmt.sv
module i2cs_addr_fmt
  import i2cs_pkg::*;
(
  input  seg_t       seg,
  output logic [7:0] first_byte,
  output logic [7:0] second_byte
);

  always_comb begin
    if (seg.ten) first_byte = {5'b11110, seg.addr[9:8], seg.rd};
    else         first_byte = {seg.addr[6:0], seg.rd};
    second_byte = seg.addr[7:0];
  end

endmodule

// File: rtl/i2cs_watchdog.sv
module i2cs_watchdog #(
  parameter int WD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            kick,
  input  logic [WD_W-1:0] limit,
  output logic            expired
);

  localparam logic [WD_W-1:0] CNT_MAX = '1;

  logic [WD_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || kick)     cnt <= '0;
    else if (cnt != CNT_MAX)   cnt <= cnt + 1'b1;
  end

  assign expired = run && !kick && (cnt >= limit);

endmodule

// File: rtl/i2cs_rd_stage.sv
module i2cs_rd_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] din,
  input  logic       flush,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= din;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R5: an offered byte is held until taken
  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/i2c_seg_seq.sv
module i2c_seg_seq
  import i2cs_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int WD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WD_W-1:0]   timeout_cycles,
  input  logic              seg_valid,
  output logic              seg_ready,
  input  logic [9:0]        seg_addr,
  input  logic              seg_ten,
  input  logic              seg_rd,
  input  logic              seg_nors,
  input  logic              seg_last,
  input  logic [LEN_W-1:0]  seg_len,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [7:0]        wd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              ctl_cmd_valid,
  output logic [7:0]        ctl_cmd,
  output logic [7:0]        ctl_wdata,
  input  logic              ctl_tip,
  input  logic              ctl_busy,
  input  logic              ctl_nack,
  input  logic              ctl_arblost,
  input  logic [7:0]        ctl_rdata,
  output logic              done,
  output logic              err,
  output logic [2:0]        err_code
);

  state_e          state;
  phase_e          phase;
  seg_t            seg_q;
  logic [LEN_W-1:0] len_q, pos_q;
  err_e            code_q, errc_q;
  logic            cmd_vld_q, done_q, err_q;
  logic [7:0]      cmd_q, dat_q;
  logic [7:0]      first_byte, second_byte;
  logic            wd_exp, kick, poll_done, rd_load;
  logic            seg_hs, wd_hs, rd_hs;

  i2cs_addr_fmt u_fmt (
    .seg         (seg_q),
    .first_byte  (first_byte),
    .second_byte (second_byte)
  );

  assign seg_ready = (state == S_IDLE) || (state == S_FETCH);
  assign wd_ready  = (state == S_WDATA);
  assign seg_hs    = seg_valid && seg_ready;
  assign wd_hs     = wd_valid && wd_ready;
  assign rd_hs     = rd_valid && rd_ready;
  assign kick      = cmd_vld_q || seg_hs || wd_hs || rd_hs;
  assign poll_done = (state == S_POLL) && !ctl_tip;
  assign rd_load   = poll_done && (phase == PH_READ) && !ctl_arblost;

  i2cs_watchdog #(.WD_W(WD_W)) u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state != S_IDLE),
    .kick    (kick),
    .limit   (timeout_cycles),
    .expired (wd_exp)
  );

  i2cs_rd_stage u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_load && !wd_exp),
    .din       (ctl_rdata),
    .flush     (wd_exp),
    .out_valid (rd_valid),
    .out_ready (rd_ready),
    .out_data  (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      phase     <= PH_STOP;
      seg_q     <= '0;
      len_q     <= '0;
      pos_q     <= '0;
      code_q    <= ERR_NONE;
      errc_q    <= ERR_NONE;
      cmd_vld_q <= 1'b0;
      cmd_q     <= '0;
      dat_q     <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      cmd_vld_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      if (wd_exp) begin
        err_q  <= 1'b1;
        errc_q <= (state == S_INIT) ? ERR_BUSY : ERR_TIMEOUT;
        state  <= S_IDLE;
      end else begin
        unique case (state)
          S_IDLE: if (seg_valid) begin
            seg_q  <= '{addr: seg_addr, ten: seg_ten, rd: seg_rd, last: seg_last};
            len_q  <= seg_len;
            pos_q  <= '0;
            code_q <= ERR_NONE;
            state  <= S_INIT;
          end
          S_INIT: if (!ctl_busy && !ctl_tip) state <= S_ADDR;
          S_ADDR: begin
            cmd_vld_q <= 1'b1;
            cmd_q     <= CMD_START;
            dat_q     <= first_byte;
            phase     <= PH_ADDR_HI;
            state     <= S_WAIT;
          end
          S_WAIT: state <= S_POLL;
          S_POLL: if (!ctl_tip) begin
            if (phase == PH_STOP) begin
              cmd_vld_q <= 1'b1;
              cmd_q     <= CMD_IACK;
              state     <= S_IDLE;
              if (code_q == ERR_NONE) done_q <= 1'b1;
              else begin
                err_q  <= 1'b1;
                errc_q <= code_q;
              end
            end else if (ctl_arblost || (phase != PH_READ && ctl_nack)) begin
              code_q    <= ctl_arblost ? ERR_ARB : ERR_NACK;
              cmd_vld_q <= 1'b1;
              cmd_q     <= CMD_STOP;
              phase     <= PH_STOP;
              state     <= S_WAIT;
            end else if (phase == PH_ADDR_HI && seg_q.ten) begin
              cmd_vld_q <= 1'b1;
              cmd_q     <= CMD_WRITE;
              dat_q     <= second_byte;
              phase     <= PH_ADDR_LO;
              state     <= S_WAIT;
            end else if (phase == PH_READ) begin
              pos_q <= pos_q + 1'b1;
              state <= S_RDOUT;
            end else begin
              state <= S_NEXT;
            end
          end
          S_NEXT: begin
            if (pos_q == len_q) begin
              if (seg_q.last) begin
                cmd_vld_q <= 1'b1;
                cmd_q     <= CMD_STOP;
                phase     <= PH_STOP;
                state     <= S_WAIT;
              end else begin
                state <= S_FETCH;
              end
            end else if (seg_q.rd) begin
              cmd_vld_q <= 1'b1;
              cmd_q     <= (pos_q == len_q - 1'b1) ? CMD_RD_NACK : CMD_RD_ACK;
              phase     <= PH_READ;
              state     <= S_WAIT;
            end else begin
              state <= S_WDATA;
            end
          end
          S_WDATA: if (wd_valid) begin
            cmd_vld_q <= 1'b1;
            cmd_q     <= CMD_WRITE;
            dat_q     <= wd_data;
            pos_q     <= pos_q + 1'b1;
            phase     <= PH_WRITE;
            state     <= S_WAIT;
          end
          S_RDOUT: if (rd_hs) state <= S_NEXT;
          S_FETCH: if (seg_valid) begin
            seg_q <= '{addr: seg_addr, ten: seg_ten, rd: seg_rd, last: seg_last};
            len_q <= seg_len;
            pos_q <= '0;
            state <= seg_nors ? S_NEXT : S_ADDR;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign ctl_cmd_valid = cmd_vld_q;
  assign ctl_cmd       = cmd_q;
  assign ctl_wdata     = dat_q;
  assign done          = done_q;
  assign err           = err_q;
  assign err_code      = errc_q;

  // R10: command strobes never come back to back
  p_cmd_spaced_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_cmd_valid |=> !ctl_cmd_valid);

  // R4: an accepted write byte goes out with the next command
  p_wd_forward_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && wd_ready) |=> (ctl_cmd_valid && ctl_cmd == CMD_WRITE &&
                                ctl_wdata == $past(wd_data)));

  // R11: watchdog expiry ends the transaction next cycle
  p_timeout_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wd_exp |=> (err && seg_ready &&
                (err_code == ERR_TIMEOUT || err_code == ERR_BUSY)));

  // R6: any error report carries a non-zero code
  p_err_coded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (err_code != ERR_NONE && !done));

  // R9: completion coincides with the acknowledge command
  p_done_iack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ctl_cmd_valid && ctl_cmd == CMD_IACK));

endmodule

// File: tb/sim_i2c_seg_seq.sv
module sim_i2c_seg_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] timeout_cycles = 16'd200;
  logic        seg_valid, seg_ready, seg_ten, seg_rd, seg_nors, seg_last;
  logic [9:0]  seg_addr;
  logic [7:0]  seg_len;
  logic        wd_valid, wd_ready, rd_valid, rd_ready;
  logic [7:0]  wd_data, rd_data;
  logic        ctl_cmd_valid;
  logic [7:0]  ctl_cmd, ctl_wdata, ctl_rdata;
  logic        ctl_tip, ctl_busy, ctl_nack, ctl_arblost;
  logic        done, err;
  logic [2:0]  err_code;

  always #4 clk = ~clk;

  i2c_seg_seq u0 (.*);

  // scenario storage
  logic [9:0] s_addr [0:7];
  logic       s_ten [0:7];
  logic       s_rd [0:7];
  logic       s_nors [0:7];
  int         s_len [0:7];
  int         nseg;
  logic [7:0] wbytes [0:63];
  int         nwb;

  // expected
  logic [7:0] e_cmd [0:127];
  logic [7:0] e_dat [0:127];
  bit         e_dc [0:127];
  int         e_n, e_code;
  logic [7:0] e_rd [0:63];
  int         e_rn;

  // bench state
  bit  armed = 0, clr = 0, hang = 0, wd_go = 1, ended = 0;
  int  sd_ptr, wd_ptr, rd_n, log_n, tip_cnt, tip_viol, first_cmd_cyc;
  int  nack_at = -1, arb_at = -1, cyc = 0;
  logic [7:0] log_cmd [0:127];
  logic [7:0] log_dat [0:127];
  logic [7:0] rd_got [0:63];
  int  nchk = 0, nfail = 0;

  assign seg_valid = armed && (sd_ptr < nseg);
  assign seg_addr  = s_addr[sd_ptr[2:0]];
  assign seg_ten   = s_ten[sd_ptr[2:0]];
  assign seg_rd    = s_rd[sd_ptr[2:0]];
  assign seg_nors  = s_nors[sd_ptr[2:0]];
  assign seg_len   = 8'(s_len[sd_ptr[2:0]]);
  assign seg_last  = (sd_ptr == nseg - 1);
  assign wd_valid  = armed && (wd_ptr < nwb) && wd_go;
  assign wd_data   = wbytes[wd_ptr[5:0]];

  always @(negedge clk) begin
    wd_go    <= ($urandom % 4) != 0;
    rd_ready <= ($urandom % 3) != 0;
  end

  // controller model and stream bookkeeping
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      ctl_tip <= 1'b0; ctl_nack <= 1'b0; ctl_arblost <= 1'b0; ctl_rdata <= 8'h00;
      tip_cnt = 0;
    end else begin
      if (ctl_cmd_valid) begin
        if (ctl_tip) tip_viol = tip_viol + 1;
        if (log_n == 0) first_cmd_cyc = cyc;
        log_cmd[log_n[6:0]] = ctl_cmd;
        log_dat[log_n[6:0]] = ctl_wdata;
        ctl_nack    <= (log_n == nack_at);
        ctl_arblost <= (log_n == arb_at);
        ctl_rdata   <= 8'(log_n * 37 + 11);
        log_n   = log_n + 1;
        tip_cnt = 1 + int'($urandom % 4);
        ctl_tip <= 1'b1;
      end else if (ctl_tip && !hang) begin
        tip_cnt = tip_cnt - 1;
        if (tip_cnt <= 0) ctl_tip <= 1'b0;
      end
    end
    if (clr) begin
      sd_ptr <= 0; wd_ptr <= 0; rd_n <= 0;
      log_n = 0; tip_viol = 0; first_cmd_cyc = -1;
    end else begin
      if (seg_valid && seg_ready) sd_ptr <= sd_ptr + 1;
      if (wd_valid && wd_ready)   wd_ptr <= wd_ptr + 1;
      if (rd_valid && rd_ready) begin
        rd_got[rd_n[5:0]] = rd_data;
        rd_n <= rd_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_seg(input int i, input int a, input bit ten, input bit rd,
                         input bit nors, input int len);
    s_addr[i] = 10'(a); s_ten[i] = ten; s_rd[i] = rd; s_nors[i] = nors; s_len[i] = len;
  endtask

  task automatic fill_wbytes();
    nwb = 0;
    for (int i = 0; i < nseg; i++)
      if (!s_rd[i]) nwb += s_len[i];
    for (int i = 0; i < 64; i++) wbytes[i] = 8'($urandom);
  endtask

  task automatic push(input logic [7:0] c, input logic [7:0] d, input bit dc);
    e_cmd[e_n[6:0]] = c; e_dat[e_n[6:0]] = d; e_dc[e_n[6:0]] = dc; e_n++;
  endtask

  // expected command list from the requirements (R2, R3, R4, R5, R8, R9)
  task automatic build_full();
    int k = 0;
    e_n = 0;
    for (int i = 0; i < nseg; i++) begin
      if (i == 0 || !s_nors[i]) begin
        if (s_ten[i]) begin
          push(8'h91, {5'b11110, s_addr[i][9:8], s_rd[i]}, 0);
          push(8'h11, s_addr[i][7:0], 0);
        end else begin
          push(8'h91, {s_addr[i][6:0], s_rd[i]}, 0);
        end
      end
      for (int b = 0; b < s_len[i]; b++) begin
        if (s_rd[i]) push((b == s_len[i] - 1) ? 8'h29 : 8'h21, 8'h00, 1);
        else begin push(8'h11, wbytes[k[5:0]], 0); k++; end
      end
    end
    push(8'h41, 8'h00, 1);
    push(8'h01, 8'h00, 1);
    e_code = 0;
  endtask

  // kind: 0 none, 1 nack (R6), 2 arbitration (R7)
  task automatic apply_fault(input int kind);
    int j, lim;
    nack_at = -1; arb_at = -1;
    lim = e_n;
    if (kind == 1) begin
      do j = int'($urandom % (e_n - 2));
      while (!(e_cmd[j[6:0]] == 8'h91 || e_cmd[j[6:0]] == 8'h11));
      nack_at = j; e_n = j + 1; lim = e_n; e_code = 2;
      push(8'h41, 8'h00, 1); push(8'h01, 8'h00, 1);
    end else if (kind == 2) begin
      j = int'($urandom % (e_n - 2));
      arb_at = j; e_n = j + 1; lim = j; e_code = 3;
      push(8'h41, 8'h00, 1); push(8'h01, 8'h00, 1);
    end
    e_rn = 0;
    for (int i = 0; i < lim; i++)
      if (e_cmd[i[6:0]] == 8'h21 || e_cmd[i[6:0]] == 8'h29) begin
        e_rd[e_rn[5:0]] = 8'(i * 37 + 11); e_rn++;
      end
  endtask

  task automatic start_txn();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0; armed = 1;
  endtask

  task automatic wait_end(output int code);
    int n = 0;
    code = -1;
    while (n < 3000 && code < 0) begin
      @(negedge clk);
      if (done) code = 0;
      else if (err) code = int'(err_code);
      n++;
    end
    armed = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic compare(input string req, input int code);
    int bad = -1;
    chk(code == e_code, req, "end code", code, e_code);
    chk(log_n == e_n, req, "command count", log_n, e_n);
    for (int i = 0; i < e_n && i < log_n; i++)
      if (bad < 0 && (log_cmd[i[6:0]] != e_cmd[i[6:0]] ||
                      (!e_dc[i[6:0]] && log_dat[i[6:0]] != e_dat[i[6:0]]))) bad = i;
    if (bad >= 0)
      chk(0, req, "command/data at index", {log_cmd[bad[6:0]], log_dat[bad[6:0]]},
          {e_cmd[bad[6:0]], e_dat[bad[6:0]]});
    else chk(1, req, "", 0, 0);
    chk(rd_n == e_rn, "R5", "read byte count", rd_n, e_rn);
    for (int i = 0; i < e_rn && i < rd_n; i++)
      if (rd_got[i[5:0]] != e_rd[i[5:0]])
        chk(0, "R5", "read byte", rd_got[i[5:0]], e_rd[i[5:0]]);
    chk(tip_viol == 0, "R10", "command during transfer", tip_viol, 0);
  endtask

  task automatic run_case(input string req, input int kind);
    int code;
    fill_wbytes(); build_full(); apply_fault(kind);
    start_txn(); wait_end(code); compare(req, code);
  endtask

  initial begin
    int code, rel;
    void'($urandom(32'h1C2D));
    armed = 0; ctl_busy = 0; nseg = 0; nwb = 0; rd_ready = 1;
    for (int i = 0; i < 8; i++) set_seg(i, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(seg_ready == 1, "R12", "seg_ready after reset", seg_ready, 1);
    chk(!ctl_cmd_valid && !done && !err && !rd_valid, "R12", "quiet outputs after reset",
        {ctl_cmd_valid, done, err, rd_valid}, 0);

    // R2 R4 R9: 7-bit write
    nseg = 1; set_seg(0, 7'h52, 0, 0, 0, 2); run_case("R2", 0);
    // R3 R5: 10-bit read
    nseg = 1; set_seg(0, 10'h2C7, 1, 1, 0, 3); run_case("R3", 0);
    // R4: zero-length write sends only the address
    nseg = 1; set_seg(0, 7'h1F, 0, 0, 0, 0); run_case("R4", 0);
    // R8: write then read with repeated START
    nseg = 2; set_seg(0, 7'h50, 0, 0, 0, 1); set_seg(1, 7'h50, 0, 1, 0, 2);
    run_case("R8", 0);
    // R8: no-restart continuation
    nseg = 2; set_seg(0, 10'h155, 1, 0, 0, 2); set_seg(1, 0, 0, 0, 1, 2);
    run_case("R8", 0);
    // R6: nack on the address
    nseg = 1; set_seg(0, 7'h33, 0, 0, 0, 2);
    fill_wbytes(); build_full(); apply_fault(0); nack_at = 0; e_n = 1; e_code = 2;
    push(8'h41, 8'h00, 1); push(8'h01, 8'h00, 1);
    start_txn(); wait_end(code); compare("R6", code);
    // R6: nack on a written byte
    nseg = 1; set_seg(0, 7'h34, 0, 0, 0, 3); run_case("R6", 1);
    // R7: arbitration lost during a read
    nseg = 1; set_seg(0, 7'h35, 0, 1, 0, 4); run_case("R7", 2);

    // R1 R12: wait while bus busy, then proceed
    nseg = 1; set_seg(0, 7'h11, 0, 0, 0, 1); fill_wbytes(); build_full(); apply_fault(0);
    ctl_busy = 1; start_txn();
    repeat (30) @(negedge clk);
    chk(seg_ready == 0, "R12", "seg_ready during active segment", seg_ready, 0);
    chk(first_cmd_cyc < 0, "R1", "command issued while busy", first_cmd_cyc, -1);
    rel = cyc; ctl_busy = 0;
    wait_end(code); compare("R1", code);
    chk(first_cmd_cyc > rel, "R1", "first command cycle", first_cmd_cyc, rel + 1);

    // R1: permanent busy gives busy error
    nseg = 1; set_seg(0, 7'h12, 0, 0, 0, 1); fill_wbytes();
    nack_at = -1; arb_at = -1; ctl_busy = 1; start_txn(); wait_end(code); ctl_busy = 0;
    chk(code == 1, "R1", "busy timeout code", code, 1);
    chk(log_n == 0, "R1", "commands during busy", log_n, 0);

    // R11: stuck transfer gives timeout without STOP
    nseg = 1; set_seg(0, 7'h13, 0, 0, 0, 1); fill_wbytes();
    hang = 1; start_txn(); wait_end(code);
    chk(code == 4, "R11", "timeout code", code, 4);
    chk(log_n == 1 && log_cmd[0] == 8'h91, "R11", "commands before timeout", log_n, 1);
    hang = 0; rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);

    // random transactions
    for (int t = 0; t < 40; t++) begin
      nseg = 1 + int'($urandom % 3);
      for (int i = 0; i < nseg; i++) begin
        bit ten = 1'($urandom);
        set_seg(i, ten ? int'($urandom % 1024) : int'($urandom % 128), ten,
                1'($urandom), 1'($urandom), int'($urandom % 5));
      end
      run_case("R8", int'($urandom % 3));
    end

    ended = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      nchk++; nfail++;
      $display("FAIL R11 bench watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

endmodule